// File: doc/BRIEF.md
# Strobe-Framed Serial Word Receiver

This block is the host end of a three-wire serial link that carries one conversion result per frame. A frame is marked by an active-low strobe. While the strobe is low, the sender shifts out sixteen bits, one per serial clock period. The first two bits are always zero and act as a format marker. The remaining fourteen bits are the result, most significant bit first. The receiver takes a bit on each falling edge of the serial clock, and only while the strobe is low.

All three link lines are asynchronous to the system clock. Each line passes through a two-register synchroniser, and edges are then found in the system clock domain. The serial clock may run freely between frames, or it may stop and be pulled high. Clock edges seen while the strobe is high are discarded, and a clock parked high never counts as an edge. At the close of each frame (the strobe rising), the block does one of two things. If the frame is well formed, it loads the 14-bit result and pulses a valid flag for one cycle. If not, it pulses a framing-error flag for one cycle.

Top module: `strb_word_rx`

## Requirements
- R1: While reset is high, and after it is released, `res_vld_o` and `frm_err_o` are 0 and `res_o` is 0 until the first good frame.
- R2: While the strobe is low, each falling edge of `lnk_clk_i` captures `lnk_dat_i`, first bit first. In a good frame, bits 3..16 form `res_o[13:0]`, with bit 3 as the most significant.
- R3: A good frame gives `res_vld_o` high for exactly one cycle. It is seen at the third rising `clk` edge after the strobe rises at the pin, and `res_o` is updated on that same edge.
- R4: Serial clock edges and data seen while the strobe is high do not change the captured word or the bit count, even with a free-running serial clock.
- R5: A serial clock that stays high (stopped or pulled up), including through reset release and strobe fall, is not counted as a bit.
- R6: If the bit count at strobe rise is not exactly 16 (fewer, none, or more, with the count saturating), `frm_err_o` pulses for one cycle at the R3 timing, there is no valid pulse, and `res_o` keeps its old value.
- R7: If the first or the second captured bit is 1, `frm_err_o` pulses instead of `res_vld_o`, and `res_o` keeps its old value.
- R8: Every falling edge of the strobe clears the bit count and the partial word, so a good frame that follows an aborted or malformed one is received correctly.
- R9: `res_vld_o` and `frm_err_o` are never high together, and each frame end yields exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_clk_i | input | 1 | Serial clock from the link, asynchronous, idles high |
| lnk_dat_i | input | 1 | Serial data from the link, asynchronous |
| lnk_stb_n_i | input | 1 | Active-low frame strobe, asynchronous |
| res_o | output | 14 | Last good 14-bit result |
| res_vld_o | output | 1 | One-cycle pulse when `res_o` has been loaded |
| frm_err_o | output | 1 | One-cycle pulse on a malformed frame |

## Verification
Every frame outcome is due exactly three system clock edges after the strobe is driven high. Two edges are spent in the synchroniser, and the third is the registered decision. The bench stamps the cycle in which it raises the strobe, and it stamps the cycle in which a monitor sampling on the falling clock edge first sees either pulse. It then checks that the difference is exactly three. The outcome counts and `res_o` are compared only after a settling gap of several cycles, so a late or early pulse cannot pass as the current frame's result. The serial half period is kept at two or more system clocks, so that each link level survives synchronisation.

// File: rtl/strb_word_rx_pkg.sv
package strb_word_rx_pkg;
  // Positions of the link lines inside the synchroniser vectors
  localparam int LN_CLK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_STB = 2;
  localparam int LN_NUM = 3;
  // Level each line is assumed to hold while idle / in reset
  localparam logic [LN_NUM-1:0] LN_IDLE = 3'b101;
endpackage

// File: rtl/strb_word_rx_sync.sv
module strb_word_rx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[g]}};
      else     chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign lvl_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/strb_word_rx_edge.sv
module strb_word_rx_edge #(
  parameter int N = 2,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl_i;
  end
  assign chg_o = lvl_i ^ prev;
endmodule

// File: rtl/strb_word_rx_shift.sv
module strb_word_rx_shift #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          clr,
  output logic [W-1:0]  sreg_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(W + 1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_o <= '0;
      cnt_o  <= '0;
    end else if (bit_stb) begin
      sreg_o <= clr ? {{(W-1){1'b0}}, bit_val} : {sreg_o[W-2:0], bit_val};
      if (clr)                  cnt_o <= CNT_ONE;
      else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_ONE;
    end else if (clr) begin
      sreg_o <= '0;
      cnt_o  <= '0;
    end
  end

  // R8: a strobe fall with no bit in the same cycle leaves an empty count
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !bit_stb) |=> (cnt_o == '0));
  // R6: the counter saturates one past a full word
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CNT_MAX);
  // R2: a captured bit always leaves a nonzero count
  p_cnt_bit_r2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> (cnt_o != '0));
endmodule

// File: rtl/strb_word_rx_check.sv
module strb_word_rx_check #(
  parameter int W     = 16,
  parameter int RES_W = 14,
  localparam int CW   = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_end,
  input  logic [W-1:0]     sreg_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [RES_W-1:0] res_o,
  output logic             vld_o,
  output logic             err_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  logic good;
  assign good = (cnt_i == CNT_FULL) && (sreg_i[W-1:RES_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      vld_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      vld_o <= frame_end && good;
      err_o <= frame_end && !good;
      if (frame_end && good) res_o <= sreg_i[RES_W-1:0];
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vld_o, err_o}));
  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> $stable(res_o));
endmodule

// File: rtl/strb_word_rx.sv
module strb_word_rx
  import strb_word_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RES_W  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lnk_clk_i,
  input  logic             lnk_dat_i,
  input  logic             lnk_stb_n_i,
  output logic [RES_W-1:0] res_o,
  output logic             res_vld_o,
  output logic             frm_err_o
);
  localparam int CW = $clog2(WORD_W + 2);

  logic [LN_NUM-1:0] raw, lvl;
  logic [1:0]        chg;
  logic              clk_fall, stb_fall, stb_rise, bit_stb;
  logic [WORD_W-1:0] sreg;
  logic [CW-1:0]     cnt;

  assign raw[LN_CLK] = lnk_clk_i;
  assign raw[LN_DAT] = lnk_dat_i;
  assign raw[LN_STB] = lnk_stb_n_i;

  strb_word_rx_sync #(.N(LN_NUM), .STAGES(SYNC_STAGES), .IDLE(LN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .lvl_o(lvl));

  strb_word_rx_edge #(.N(2), .IDLE(2'b11)) u_edge (
    .clk(clk), .rst(rst), .lvl_i({lvl[LN_STB], lvl[LN_CLK]}), .chg_o(chg));

  assign clk_fall = chg[0] && !lvl[LN_CLK];
  assign stb_fall = chg[1] && !lvl[LN_STB];
  assign stb_rise = chg[1] &&  lvl[LN_STB];
  assign bit_stb  = clk_fall && !lvl[LN_STB];

  strb_word_rx_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(lvl[LN_DAT]),
    .clr(stb_fall), .sreg_o(sreg), .cnt_o(cnt));

  strb_word_rx_check #(.W(WORD_W), .RES_W(RES_W)) u_check (
    .clk(clk), .rst(rst), .frame_end(stb_rise), .sreg_i(sreg), .cnt_i(cnt),
    .res_o(res_o), .vld_o(res_vld_o), .err_o(frm_err_o));
endmodule

// File: tb/strb_word_rx_test.sv
`timescale 1ns/1ps
module strb_word_rx_test;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, sdat = 1'b0, stb_n = 1'b1;
  logic [13:0] res;
  logic vld, err;
  int cyc = 0, nchk = 0, nerr = 0;
  int nv = 0, ne = 0, both = 0, wide = 0, ev_cyc = 0, rise_cyc = 0;
  bit fr = 1'b0, done = 1'b0, pv = 1'b0, pe = 1'b0;
  int H = 2;
  logic [13:0] exp_res = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strb_word_rx uut (.clk(clk), .rst(rst), .lnk_clk_i(sclk), .lnk_dat_i(sdat),
    .lnk_stb_n_i(stb_n), .res_o(res), .res_vld_o(vld), .frm_err_o(err));

  always @(negedge clk) if (!rst) begin
    if (vld) begin nv++; ev_cyc = cyc; end
    if (err) begin ne++; ev_cyc = cyc; end
    if (vld && err) both++;
    if ((vld && pv) || (err && pe)) wide++;
    pv = vld; pe = err;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle_link(int n);
    for (int i = 0; i < n; i++) begin
      if (fr) begin sclk = ~sclk; sdat = 1'($urandom); end
      tick(H);
    end
    if (sclk == 1'b0) begin sclk = 1'b1; tick(H); end
  endtask

  function automatic bit is_good(logic [39:0] b, int nb);
    return (nb == 16) && (b[15:14] == 2'b00);
  endfunction

  task automatic send(logic [39:0] b, int nb, string req);
    int v0, e0;
    bit g;
    g = is_good(b, nb);
    v0 = nv; e0 = ne;
    idle_link(5);
    stb_n = 1'b0; tick(H);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1; sdat = b[nb-1-i]; tick(H);
      sclk = 1'b0; tick(H);
    end
    sclk = 1'b1; tick(H);
    rise_cyc = cyc; stb_n = 1'b1;
    idle_link(5);
    tick(6);
    if (g) exp_res = b[13:0];
    chk(nv - v0 == int'(g), req, "valid pulses", nv - v0, int'(g));
    chk(ne - e0 == int'(!g), req, "error pulses", ne - e0, int'(!g));
    chk(res == exp_res, req, "result", res, exp_res);
    chk(ev_cyc - rise_cyc == 3, "R3", "outcome latency", ev_cyc - rise_cyc, 3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(2);
    chk(vld == 1'b0, "R1", "valid in reset", vld, 0);
    chk(err == 1'b0, "R1", "error in reset", err, 0);
    tick(3); rst = 1'b0; tick(2);
    chk(res == '0, "R1", "result after reset", res, 0);
    // R5: clock parked high with strobe low and high, no edges taken
    stb_n = 1'b0; tick(30); stb_n = 1'b1; tick(30);
    chk(ne == 1, "R5", "idle strobe pulse counts no bits", ne, 1);
    chk(nv == 0, "R5", "no valid from idle", nv, 0);
    // Directed gated-clock frames (R2, R3)
    fr = 0; H = 2;
    send({24'd0, 2'b00, 14'h3FFF}, 16, "R2");
    send({24'd0, 2'b00, 14'h0000}, 16, "R2");
    send({24'd0, 2'b00, 14'h2AAA}, 16, "R2");
    // R4: free-running clock outside strobe
    fr = 1; H = 3;
    send({24'd0, 2'b00, 14'h1357}, 16, "R4");
    // R7: leading bits not zero
    send({24'd0, 2'b10, 14'h0F0F}, 16, "R7");
    send({24'd0, 2'b01, 14'h00F0}, 16, "R7");
    // R6: wrong bit counts
    fr = 0;
    send({25'd0, 15'h0123}, 15, "R6");
    send({23'd0, 17'h00456}, 17, "R6");
    send(40'd0, 0, "R6");
    send(40'h0000_0000_00, 40, "R6");
    // R8: aborted frame then good frame
    send({33'd0, 7'h5A}, 7, "R8");
    send({24'd0, 2'b00, 14'h1C3A}, 16, "R8");
    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [39:0] b;
      int nb;
      fr = 1'($urandom);
      H = 2 + int'($urandom_range(0, 2));
      nb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(12, 20)) : 16;
      b = {$urandom(), $urandom()};
      if ($urandom_range(0, 2) != 0) b[15:14] = 2'b00;
      send(b, nb, fr ? "R4" : "R2");
    end
    chk(both == 0, "R9", "valid and error together", both, 0);
    chk(wide == 0, "R9", "pulses wider than one cycle", wide, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule